// File: doc/BRIEF.md
# Reloadable Interval Timer Group

A bank of four independent down-counting interval timers, all driven by one shared tick enable and programmed through a plain register read/write port. Each timer has three registers. A limit register holds a count-inhibit bit and a 31-bit reload value. A read-only count register shows the live count and a reload-parity (toggle) bit. An attribute register holds an interrupt mask, a sticky activity flag, a priority and a vector.

While a timer is enabled, each tick lowers its count by one. A tick that arrives while the count is zero reloads the count from the limit register, inverts the toggle bit and fires the timer. A fire on an unmasked timer produces a one-cycle request that carries that timer's vector and priority. Arbitration between requesters and delivery to a core happen outside this block. Software starts a timer by clearing the inhibit bit. A new reload value written while the timer runs takes effect only at the next expiry.

Top module: `ivt_group`

## Requirements
- R1: After reset every limit register reads 0x8000_0000 (inhibit set, reload 0), every count register reads 0, every attribute register reads 0x8000_0000 (mask set), and no request is raised. Address = {timer index, select}; select 0 = limit, 1 = count, 2 = attribute, 3 reads 0.
- R2: While a timer's inhibit bit (limit bit 31) is 1, its count holds its value on ticks and it raises no request.
- R3: A limit write that changes inhibit from 1 to 0 loads the count with the reload field of the same write (bits 30:0) and clears the toggle bit (count register bit 31).
- R4: While running, each tick decrements a nonzero count by one. A tick at count zero reloads the stored reload value, inverts the toggle bit and fires the timer, so the timer fires once every reload+1 ticks.
- R5: With a reload value of zero, a running timer fires on every tick.
- R6: A limit write with inhibit 0 to a running timer does not disturb the count. The new reload value is used from the next expiry on.
- R7: A fire of an unmasked timer raises that timer's irq_req for exactly the following clock cycle, with irq_vec and irq_pri holding the attribute register's vector (bits 15:0) and priority (bits 19:16). When the mask (attribute bit 31) is 1, no request is raised.
- R8: The activity flag (attribute bit 30, read only) becomes 1 together with an unmasked request and stays 1 until a one-cycle pulse on that timer's irq_ack.
- R9: Timers are independent: programming or running one timer leaves the others unchanged. Writes to a count register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Shared count enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address {timer, select} |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq_ack | input | 4 | Per-timer acknowledge pulse |
| irq_req | output | 4 | Per-timer one-cycle request |
| irq_vec | output | 64 | Per-timer vector, timer i at [16i+15:16i] |
| irq_pri | output | 16 | Per-timer priority, timer i at [4i+3:4i] |

## Verification
The assertions check four things on every cycle. A stopped count never moves unless the limit register is written. A request always follows a tick with the mask clear. Each request comes with a set activity flag. The activity flag only falls on an acknowledge. The reload arithmetic can only be shown by the bench's scenarios: the fire count and residual count over swept reload values and tick counts, the deferred reload, the clearing of the toggle bit at start, and the vector and priority that travel with a request.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int REG_W = 32;
  typedef enum logic [1:0] {
    SEL_LIMIT = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_ATTR  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
  localparam int ATTR_MSK_BIT = 31;
  localparam int ATTR_ACT_BIT = 30;
  localparam int ATTR_PRI_LSB = 16;
endpackage

// File: rtl/ivt_channel.sv
module ivt_channel #(
  parameter int CW = 31,
  parameter int VW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          lim_we,
  input  logic          attr_we,
  input  logic [31:0]   wdata,
  input  logic          ack,
  output logic [CW-1:0] reload_o,
  output logic          inh_o,
  output logic [CW-1:0] cnt_o,
  output logic          tgl_o,
  output logic          msk_o,
  output logic          act_o,
  output logic [VW-1:0] vec_o,
  output logic [PW-1:0] pri_o,
  output logic          irq_o
);
  import ivt_pkg::*;

  logic [CW-1:0] reload_q, reload_d, cnt_q, cnt_d;
  logic          inh_q, inh_d, tgl_q, tgl_d, msk_q, msk_d, act_q, act_d, irq_q, irq_d;
  logic [VW-1:0] vec_q, vec_d;
  logic [PW-1:0] pri_q, pri_d;
  logic          start, fire;

  always_comb begin
    reload_d = reload_q;
    inh_d    = inh_q;
    cnt_d    = cnt_q;
    tgl_d    = tgl_q;
    msk_d    = msk_q;
    vec_d    = vec_q;
    pri_d    = pri_q;
    fire     = 1'b0;
    start    = lim_we && inh_q && !wdata[31];
    if (lim_we) begin
      reload_d = wdata[CW-1:0];
      inh_d    = wdata[31];
    end
    if (start) begin
      cnt_d = wdata[CW-1:0];
      tgl_d = 1'b0;
    end else if (!inh_q && tick) begin
      if (cnt_q == '0) begin
        cnt_d = reload_q;
        tgl_d = ~tgl_q;
        fire  = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (attr_we) begin
      msk_d = wdata[ATTR_MSK_BIT];
      pri_d = wdata[ATTR_PRI_LSB +: PW];
      vec_d = wdata[VW-1:0];
    end
    irq_d = fire && !msk_q;
    act_d = (act_q && !ack) || irq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      inh_q    <= 1'b1;
      cnt_q    <= '0;
      tgl_q    <= 1'b0;
      msk_q    <= 1'b1;
      act_q    <= 1'b0;
      vec_q    <= '0;
      pri_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      reload_q <= reload_d;
      inh_q    <= inh_d;
      cnt_q    <= cnt_d;
      tgl_q    <= tgl_d;
      msk_q    <= msk_d;
      act_q    <= act_d;
      vec_q    <= vec_d;
      pri_q    <= pri_d;
      irq_q    <= irq_d;
    end
  end

  assign reload_o = reload_q;
  assign inh_o    = inh_q;
  assign cnt_o    = cnt_q;
  assign tgl_o    = tgl_q;
  assign msk_o    = msk_q;
  assign act_o    = act_q;
  assign vec_o    = vec_q;
  assign pri_o    = pri_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/ivt_rdmux.sv
module ivt_rdmux #(
  parameter int NTMR = 4,
  parameter int CW   = 31,
  parameter int VW   = 16,
  parameter int PW   = 4,
  localparam int IW  = $clog2(NTMR),
  localparam int AW  = IW + 2
) (
  input  logic [AW-1:0]      addr,
  input  logic [NTMR*CW-1:0] reload,
  input  logic [NTMR-1:0]    inh,
  input  logic [NTMR*CW-1:0] cnt,
  input  logic [NTMR-1:0]    tgl,
  input  logic [NTMR-1:0]    msk,
  input  logic [NTMR-1:0]    act,
  input  logic [NTMR*VW-1:0] vec,
  input  logic [NTMR*PW-1:0] pri,
  output logic [31:0]        rdata
);
  import ivt_pkg::*;

  logic [IW-1:0] idx;
  reg_sel_e      sel;

  assign idx = addr[AW-1:2];
  assign sel = reg_sel_e'(addr[1:0]);

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_LIMIT: begin
        rdata[31]     = inh[idx];
        rdata[CW-1:0] = reload[idx*CW +: CW];
      end
      SEL_COUNT: begin
        rdata[31]     = tgl[idx];
        rdata[CW-1:0] = cnt[idx*CW +: CW];
      end
      SEL_ATTR: begin
        rdata[ATTR_MSK_BIT]           = msk[idx];
        rdata[ATTR_ACT_BIT]           = act[idx];
        rdata[ATTR_PRI_LSB +: PW]     = pri[idx*PW +: PW];
        rdata[VW-1:0]                 = vec[idx*VW +: VW];
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/ivt_group.sv
module ivt_group #(
  parameter int NTMR = 4,
  parameter int CW   = 31,
  parameter int VW   = 16,
  parameter int PW   = 4,
  localparam int IW  = $clog2(NTMR),
  localparam int AW  = IW + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [NTMR-1:0]    irq_ack,
  output logic [NTMR-1:0]    irq_req,
  output logic [NTMR*VW-1:0] irq_vec,
  output logic [NTMR*PW-1:0] irq_pri
);
  import ivt_pkg::*;

  logic [NTMR*CW-1:0] reload, cnt;
  logic [NTMR-1:0]    inh, tgl, msk, act, lim_we, attr_we;

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    assign lim_we[i]  = wr_en && (addr[AW-1:2] == IW'(i)) && (addr[1:0] == SEL_LIMIT);
    assign attr_we[i] = wr_en && (addr[AW-1:2] == IW'(i)) && (addr[1:0] == SEL_ATTR);

    ivt_channel #(.CW(CW), .VW(VW), .PW(PW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .lim_we   (lim_we[i]),
      .attr_we  (attr_we[i]),
      .wdata    (wdata),
      .ack      (irq_ack[i]),
      .reload_o (reload[i*CW +: CW]),
      .inh_o    (inh[i]),
      .cnt_o    (cnt[i*CW +: CW]),
      .tgl_o    (tgl[i]),
      .msk_o    (msk[i]),
      .act_o    (act[i]),
      .vec_o    (irq_vec[i*VW +: VW]),
      .pri_o    (irq_pri[i*PW +: PW]),
      .irq_o    (irq_req[i])
    );
  end

  ivt_rdmux #(.NTMR(NTMR), .CW(CW), .VW(VW), .PW(PW)) u_rd (
    .addr   (addr),
    .reload (reload),
    .inh    (inh),
    .cnt    (cnt),
    .tgl    (tgl),
    .msk    (msk),
    .act    (act),
    .vec    (irq_vec),
    .pri    (irq_pri),
    .rdata  (rdata)
  );
endmodule

// File: rtl/ivt_group_chk.sv
module ivt_group_chk #(
  parameter int NTMR = 4,
  parameter int CW   = 31
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic [NTMR-1:0]    lim_we,
  input logic [NTMR-1:0]    inh,
  input logic [NTMR*CW-1:0] cnt,
  input logic [NTMR-1:0]    msk,
  input logic [NTMR-1:0]    act,
  input logic [NTMR-1:0]    irq_ack,
  input logic [NTMR-1:0]    irq_req
);
  for (genvar i = 0; i < NTMR; i++) begin : g_chk
    // R2
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inh[i] && !lim_we[i]) |=> $stable(cnt[i*CW +: CW]));
    // R7
    req_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[i] |-> ($past(tick) && !$past(msk[i]) && !$past(inh[i])));
    // R8
    req_sets_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[i] |-> act[i]);
    // R8
    act_fall_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act[i]) |-> $past(irq_ack[i]));
  end
endmodule

bind ivt_group ivt_group_chk #(.NTMR(NTMR), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .lim_we  (lim_we),
  .inh     (inh),
  .cnt     (cnt),
  .msk     (msk),
  .act     (act),
  .irq_ack (irq_ack),
  .irq_req (irq_req)
);

// File: tb/test_ivt_group.sv
`timescale 1ns/1ps
module test_ivt_group;
  localparam int NTMR = 4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq_ack = '0;
  logic [3:0]  irq_req;
  logic [63:0] irq_vec;
  logic [15:0] irq_pri;

  int vectors = 0, miscompares = 0;
  int nirq [NTMR];
  logic [15:0] seen_vec [NTMR];
  logic [3:0]  seen_pri [NTMR];

  ivt_group i_ivt_group (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_ack(irq_ack), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_pri(irq_pri));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    for (int i = 0; i < NTMR; i++) begin
      if (irq_req[i]) begin
        nirq[i]     = nirq[i] + 1;
        seen_vec[i] = irq_vec[i*16 +: 16];
        seen_pri[i] = irq_pri[i*4 +: 4];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    vectors++;
    if (act_v !== exp_v) begin
      miscompares++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act_v, exp_v);
    end
  endtask

  task automatic wr(input int t, input int sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(t * 4 + sel); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int t, input int sel, output logic [31:0] d);
    @(negedge clk);
    addr = 4'(t * 4 + sel);
    #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int exp_n, exp_cnt, exp_tgl;
    for (int i = 0; i < NTMR; i++) nirq[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int t = 0; t < NTMR; t++) begin
      rd(t, 0, d); check("R1 limit", d, 32'h8000_0000);
      rd(t, 1, d); check("R1 count", d, 32'h0);
      rd(t, 2, d); check("R1 attr", d, 32'h8000_0000);
      rd(t, 3, d); check("R1 unused", d, 32'h0);
    end
    check("R1 irq", {28'h0, irq_req}, 32'h0);

    // R2 inhibited timer holds
    wr(0, 2, 32'h0000_0000);
    wr(0, 0, 32'h8000_0007);
    ticks(10);
    rd(0, 1, d); check("R2 held count", d, 32'h0);
    check("R2 no irq", nirq[0], 0);

    // R3 R4 R5 sweep over reload values and tick counts
    for (int b = 0; b <= 6; b++) begin
      for (int t = 0; t <= 12; t++) begin
        wr(0, 0, 32'h8000_0000 | b);
        wr(0, 0, b);
        nirq[0] = 0;
        ticks(t);
        exp_n   = t / (b + 1);
        exp_cnt = b - (t % (b + 1));
        exp_tgl = exp_n % 2;
        check(b == 0 ? "R5 fires" : "R4 fires", nirq[0], exp_n);
        rd(0, 1, d);
        check(t == 0 ? "R3 start load" : "R4 count", d, {exp_tgl[0], 31'(exp_cnt)});
      end
    end
    wr(0, 0, 32'h8000_0000);

    // R6 deferred reload
    wr(0, 0, 32'd9);
    nirq[0] = 0;
    ticks(3);
    rd(0, 1, d); check("R6 before write", d, 32'd6);
    wr(0, 0, 32'd2);
    rd(0, 1, d); check("R6 count undisturbed", d, 32'd6);
    rd(0, 0, d); check("R6 limit readback", d, 32'd2);
    ticks(7);
    rd(0, 1, d); check("R6 new reload", d, 32'h8000_0002);
    ticks(3);
    rd(0, 1, d); check("R6 second period", d, 32'h0000_0002);
    check("R6 fires", nirq[0], 2);
    wr(0, 0, 32'h8000_0000);

    // R9 count register writes ignored
    rd(0, 1, d);
    wr(0, 1, 32'h1234_5678);
    begin
      logic [31:0] d2;
      rd(0, 1, d2); check("R9 count write ignored", d2, d);
    end

    // R7 masked timer
    wr(1, 0, 32'h0);
    nirq[1] = 0;
    ticks(5);
    check("R7 masked no irq", nirq[1], 0);
    rd(1, 2, d); check("R8 masked act clear", d, 32'h8000_0000);

    // R7 R8 unmasked request with vector/priority
    wr(1, 2, 32'h000B_A5C3);
    ticks(1);
    check("R7 one request", nirq[1], 1);
    check("R7 vector", {16'h0, seen_vec[1]}, 32'h0000_A5C3);
    check("R7 priority", {28'h0, seen_pri[1]}, 32'hB);
    rd(1, 2, d); check("R8 act set", d, 32'h400B_A5C3);
    wr(1, 0, 32'h8000_0000);
    rd(1, 2, d); check("R8 act sticky", d, 32'h400B_A5C3);
    @(negedge clk); irq_ack = 4'b0010;
    @(negedge clk); irq_ack = 4'b0000;
    rd(1, 2, d); check("R8 act cleared", d, 32'h000B_A5C3);

    // R9 untouched timers
    check("R9 t2 irq", nirq[2], 0);
    check("R9 t3 irq", nirq[3], 0);
    rd(2, 1, d); check("R9 t2 count", d, 32'h0);
    rd(3, 0, d); check("R9 t3 limit", d, 32'h8000_0000);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule